// File: doc/BRIEF.md
# Accelerator Core Control and Debug Register Bank

This block is the per-core control register bank placed behind the control window of an accelerator's bus slave. Host software reads fixed identification and capability words to learn what kind of accelerator it talks to, how large its memories are and which debug features it has, then uses command writes to reset the core, start it, halt it, single-step it and program hardware breakpoints on the program counter. Status words report the run state, the live program counter, which breakpoints have fired, and two saturating performance counters.

On the core side the block drives a small run-control state machine (reset, halted, running, stepping). It holds the core in reset while loading a start address, gates the core's clock whenever it is halted, and withholds run permission in the very cycle the program counter lands on an enabled breakpoint, so the instruction at that address never retires. The register port is a simple single-cycle write strobe with a combinational read.

Top module: `accel_ctl_regs`

## Requirements
- R1: Word offset 0 reads {class[31:16], config id[15:0]} from parameters; offset 1 reads {version[31:24], core count[23:16], zero, breakpoints supported bit 1, single-step supported bit 0}; offsets 2, 3 and 4 read the instruction, data and parameter memory sizes in bytes.
- R2: After the bus reset, and for one cycle after a command write with bit 0 set, the core is in reset: `core_rst` is high and `core_start_pc` shows the start-address register (offset 10, read/write); the next cycle the core is halted.
- R3: A command write (offset 9) with bit 1 set moves a halted core to running, where `core_run_en` is high; bit 2 returns a running or stepping core to halted.
- R4: `core_cg_en` is high exactly while the core is halted, and never together with `core_run_en` or `core_rst`.
- R5: Command bit 3 moves a halted core to stepping: `core_run_en` stays high until one instruction retires (`core_retire` while `core_run_en`), then the core is halted; breakpoints are not compared while stepping.
- R6: While running, if `core_pc` equals the address of an enabled breakpoint (enable mask bits at offset 11, addresses at offsets 12 to 15), `core_run_en` is low in that cycle, the core is halted the next cycle, and sticky hit bits record every matching breakpoint until a command write with bit 5 set clears them.
- R7: The cycle counter (offset 7) counts cycles spent running and the retire counter (offset 8) counts retired instructions; both stop at their maximum value and are cleared by the bus reset, by command bit 4 and by command bit 0.
- R8: Writes to read-only offsets 0 to 8 change nothing; the command offset and every unmapped offset read 0.
- R9: When several command bits are set in one write, reset wins over halt, halt over step, and step over start.
- R10: Offset 5 reads running-or-stepping in bit 0, halted in bit 1, in-reset in bit 2 and the sticky hit bits from bit 8 upward; offset 6 reads `core_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| core_pc | input | PC_W | Core program counter |
| core_retire | input | 1 | Core reports an instruction retiring |
| core_run_en | output | 1 | Permission for the core to advance |
| core_rst | output | 1 | Holds the core in reset |
| core_cg_en | output | 1 | Clock-gate request for the core |
| core_start_pc | output | PC_W | Address loaded into the core's PC during reset |

## Verification
The embedded properties watch the run-control transitions every cycle: reset always lands in halted, a retired step or a breakpoint match always halts, the clock gate never overlaps run permission or core reset, sticky hit bits never drop without a clear, and counters never move backward or leave saturation. Which offset reads which value, the command priority ordering, the step-off-a-breakpoint sequence and the exact saturation value are shown only by the bench's scenarios, which run a behavioural model of the register bank beside the design and compare every output on every clock.

// File: rtl/accel_ctl_pkg.sv
package accel_ctl_pkg;

   typedef enum logic [1:0] {
      RC_RESET = 2'd0,
      RC_HALT  = 2'd1,
      RC_RUN   = 2'd2,
      RC_STEP  = 2'd3
   } rc_state_e;

   // command word, bit 0 is the LSB
   typedef struct packed {
      logic clr_hit;   // bit 5
      logic clr_cnt;   // bit 4
      logic step;      // bit 3
      logic halt;      // bit 2
      logic go;        // bit 1
      logic rst;       // bit 0
   } cmd_t;

   localparam int CMD_W     = 6;

   localparam int OFS_ID    = 0;
   localparam int OFS_CAPS  = 1;
   localparam int OFS_IMEM  = 2;
   localparam int OFS_DMEM  = 3;
   localparam int OFS_PMEM  = 4;
   localparam int OFS_STAT  = 5;
   localparam int OFS_PC    = 6;
   localparam int OFS_CYC   = 7;
   localparam int OFS_RET   = 8;
   localparam int OFS_CMD   = 9;
   localparam int OFS_START = 10;
   localparam int OFS_BKEN  = 11;
   localparam int OFS_BKA0  = 12;

endpackage

// File: rtl/accel_sat_cnt.sv
module accel_sat_cnt #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_w
         $error("accel_sat_cnt: CNT_W must be 1..32");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (inc && count != CNT_MAX)
         count <= count + 1'b1;
   end

   // R7: saturation holds until a clear
   p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

   // R7: never wraps downward without a clear
   p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr) |=> (count >= $past(count)));

endmodule

// File: rtl/accel_bkpt_unit.sv
module accel_bkpt_unit #(
   parameter int NUM_BKPT = 4,
   parameter int PC_W     = 32,
   parameter bit HAS_BKPT = 1'b1
) (
   input  logic [PC_W-1:0]          pc,
   input  logic [NUM_BKPT-1:0]      enable,
   input  logic [NUM_BKPT*PC_W-1:0] addr_flat,
   output logic [NUM_BKPT-1:0]      hit_vec
);
   generate
      if (HAS_BKPT) begin : g_cmp
         for (genvar i = 0; i < NUM_BKPT; i++) begin : g_slot
            assign hit_vec[i] = enable[i] && (addr_flat[i*PC_W +: PC_W] == pc);
         end
      end else begin : g_none
         assign hit_vec = '0;
      end
   endgenerate

   always_comb begin
      assert ((hit_vec & ~enable) == '0);  // R6: disabled slots never match
   end

endmodule

// File: rtl/accel_runctl.sv
module accel_runctl
   import accel_ctl_pkg::*;
#(
   parameter bit HAS_STEP = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  cmd_t      cmd,
   input  logic      bp_hit,
   input  logic      retire,
   output rc_state_e state,
   output logic      run_en,
   output logic      core_rst,
   output logic      cg_en
);
   rc_state_e nxt;
   logic      step_ok;

   generate
      if (HAS_STEP) begin : g_step
         assign step_ok = cmd.step;
      end else begin : g_nostep
         assign step_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt = state;
      if (state == RC_RESET) begin
         nxt = RC_HALT;
      end else if (cmd.rst) begin
         nxt = RC_RESET;
      end else begin
         unique case (state)
            RC_HALT: begin
               if (cmd.halt)      nxt = RC_HALT;
               else if (step_ok)  nxt = RC_STEP;
               else if (cmd.go)   nxt = RC_RUN;
            end
            RC_RUN: begin
               if (cmd.halt || bp_hit) nxt = RC_HALT;
            end
            RC_STEP: begin
               if (cmd.halt || retire) nxt = RC_HALT;
            end
            default: nxt = RC_HALT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= RC_RESET;
      else        state <= nxt;
   end

   assign run_en   = (state == RC_RUN && !bp_hit) || (state == RC_STEP);
   assign core_rst = (state == RC_RESET);
   assign cg_en    = (state == RC_HALT);

   // R2: reset state always releases into halted
   p_reset_to_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RC_RESET) |=> (state == RC_HALT));

   // R5: one retire ends a step
   p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RC_STEP && retire && !cmd.rst) |=> (state == RC_HALT));

   // R6: a breakpoint match while running halts the core
   p_bp_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RC_RUN && bp_hit && !cmd.rst) |=> (state == RC_HALT));

   // R4: clock gate exclusive with run permission and reset
   p_cg_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cg_en |-> (!run_en && !core_rst));

endmodule

// File: rtl/accel_ctl_regs.sv
module accel_ctl_regs
   import accel_ctl_pkg::*;
#(
   parameter int          ADDR_W     = 5,
   parameter int          PC_W       = 32,
   parameter int          CNT_W      = 32,
   parameter int          NUM_BKPT   = 4,
   parameter bit          HAS_STEP   = 1'b1,
   parameter bit          HAS_BKPT   = 1'b1,
   parameter logic [15:0] DEV_CLASS  = 16'h00A1,
   parameter logic [15:0] DEV_ID     = 16'h0204,
   parameter logic [7:0]  IF_VERSION = 8'd2,
   parameter logic [7:0]  NUM_CORES  = 8'd1,
   parameter int          IMEM_BYTES = 32768,
   parameter int          DMEM_BYTES = 32768,
   parameter int          PMEM_BYTES = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [PC_W-1:0]   core_pc,
   input  logic              core_retire,
   output logic              core_run_en,
   output logic              core_rst,
   output logic              core_cg_en,
   output logic [PC_W-1:0]   core_start_pc
);
   localparam int          NUM_OFS  = OFS_BKA0 + NUM_BKPT;
   localparam logic [31:0] ID_WORD  = {DEV_CLASS, DEV_ID};
   localparam logic [31:0] CAPS_WORD = {IF_VERSION, NUM_CORES, 14'd0, HAS_BKPT, HAS_STEP};

   generate
      if (NUM_BKPT < 1 || NUM_BKPT > 8) begin : g_bad_nb
         $error("accel_ctl_regs: NUM_BKPT must be 1..8");
      end
      if (PC_W < 2 || PC_W > 32) begin : g_bad_pc
         $error("accel_ctl_regs: PC_W must be 2..32");
      end
      if (NUM_OFS > (1 << ADDR_W)) begin : g_bad_aw
         $error("accel_ctl_regs: ADDR_W too small for the register map");
      end
   endgenerate

   function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   // ---------------- command decode ----------------
   cmd_t cmd;
   assign cmd = (reg_wr && at(reg_addr, OFS_CMD)) ? cmd_t'(reg_wdata[CMD_W-1:0]) : '0;

   // ---------------- writable registers ----------------
   logic [PC_W-1:0]          start_q;
   logic [NUM_BKPT-1:0]      bken_q;
   logic [PC_W-1:0]          bka_q [NUM_BKPT];
   logic [NUM_BKPT*PC_W-1:0] bka_flat;
   logic [NUM_BKPT-1:0]      hit_vec;
   logic [NUM_BKPT-1:0]      hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         bken_q  <= '0;
      end else if (reg_wr) begin
         if (at(reg_addr, OFS_START)) start_q <= reg_wdata[PC_W-1:0];
         if (at(reg_addr, OFS_BKEN))  bken_q  <= reg_wdata[NUM_BKPT-1:0];
      end
   end

   generate
      for (genvar i = 0; i < NUM_BKPT; i++) begin : g_bka
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bka_q[i] <= '0;
            else if (reg_wr && at(reg_addr, OFS_BKA0 + i))
               bka_q[i] <= reg_wdata[PC_W-1:0];
         end
         assign bka_flat[i*PC_W +: PC_W] = bka_q[i];
      end
   endgenerate

   // ---------------- breakpoints and run control ----------------
   rc_state_e state;

   accel_bkpt_unit #(
      .NUM_BKPT (NUM_BKPT),
      .PC_W     (PC_W),
      .HAS_BKPT (HAS_BKPT)
   ) i_bkpt (
      .pc        (core_pc),
      .enable    (bken_q),
      .addr_flat (bka_flat),
      .hit_vec   (hit_vec)
   );

   accel_runctl #(
      .HAS_STEP (HAS_STEP)
   ) i_runctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .bp_hit   (|hit_vec),
      .retire   (core_retire),
      .state    (state),
      .run_en   (core_run_en),
      .core_rst (core_rst),
      .cg_en    (core_cg_en)
   );

   assign core_start_pc = start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hit_q <= '0;
      else
         hit_q <= (cmd.clr_hit ? '0 : hit_q) | ((state == RC_RUN) ? hit_vec : '0);
   end

   // R6: sticky hit bits drop only on an explicit clear
   p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd.clr_hit |=> ((hit_q & $past(hit_q)) == $past(hit_q)));

   // ---------------- performance counters ----------------
   logic [CNT_W-1:0] cyc_cnt, ret_cnt;
   logic             cnt_clr;
   assign cnt_clr = cmd.clr_cnt | cmd.rst;

   accel_sat_cnt #(.CNT_W(CNT_W)) i_cyc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (state == RC_RUN),
      .count (cyc_cnt)
   );

   accel_sat_cnt #(.CNT_W(CNT_W)) i_ret (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (core_retire && core_run_en),
      .count (ret_cnt)
   );

   // ---------------- read mux ----------------
   logic [31:0] stat_word;
   always_comb begin
      stat_word       = '0;
      stat_word[0]    = (state == RC_RUN) || (state == RC_STEP);
      stat_word[1]    = (state == RC_HALT);
      stat_word[2]    = (state == RC_RESET);
      stat_word[8 +: NUM_BKPT] = hit_q;
   end

   always_comb begin
      reg_rdata = '0;
      if      (at(reg_addr, OFS_ID))    reg_rdata = ID_WORD;
      else if (at(reg_addr, OFS_CAPS))  reg_rdata = CAPS_WORD;
      else if (at(reg_addr, OFS_IMEM))  reg_rdata = 32'(IMEM_BYTES);
      else if (at(reg_addr, OFS_DMEM))  reg_rdata = 32'(DMEM_BYTES);
      else if (at(reg_addr, OFS_PMEM))  reg_rdata = 32'(PMEM_BYTES);
      else if (at(reg_addr, OFS_STAT))  reg_rdata = stat_word;
      else if (at(reg_addr, OFS_PC))    reg_rdata = 32'(core_pc);
      else if (at(reg_addr, OFS_CYC))   reg_rdata = 32'(cyc_cnt);
      else if (at(reg_addr, OFS_RET))   reg_rdata = 32'(ret_cnt);
      else if (at(reg_addr, OFS_START)) reg_rdata = 32'(start_q);
      else if (at(reg_addr, OFS_BKEN))  reg_rdata = 32'(bken_q);
      for (int i = 0; i < NUM_BKPT; i++) begin
         if (at(reg_addr, OFS_BKA0 + i)) reg_rdata = 32'(bka_q[i]);
      end
   end

   // R2: in reset the core sees the programmed start address
   p_start_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |-> (core_start_pc == start_q));

endmodule

// File: tb/test_accel_ctl_regs.sv
`timescale 1ns/100ps
module test_accel_ctl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] core_pc = '0;
   logic        core_retire = 1'b0;
   logic        core_run_en, core_rst, core_cg_en;
   logic [31:0] core_start_pc;

   int checks = 0;
   int errors = 0;
   int ncyc   = 0;
   int ret_mode = 0;   // 0 none, 1 always, 2 alternate

   always #2 clk = ~clk;  // 250 MHz

   accel_ctl_regs #(.CNT_W(8)) i_accel_ctl_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_pc(core_pc),
      .core_retire(core_retire), .core_run_en(core_run_en), .core_rst(core_rst),
      .core_cg_en(core_cg_en), .core_start_pc(core_start_pc)
   );

   // ---------------- behavioural reference ----------------
   int          m_st = 0;          // 0 reset, 1 halted, 2 running, 3 stepping
   logic [31:0] m_start = '0;
   logic [3:0]  m_ben = '0;
   logic [31:0] m_bka [4] = '{default: '0};
   logic [3:0]  m_hit = '0;
   int          m_cyc = 0, m_ret = 0;

   function automatic logic [3:0] m_hitv();
      logic [3:0] h;
      for (int i = 0; i < 4; i++) h[i] = m_ben[i] && (m_bka[i] == core_pc);
      return h;
   endfunction

   function automatic logic m_run();
      return (m_st == 2 && m_hitv() == 0) || m_st == 3;
   endfunction

   function automatic logic [31:0] m_read(input int a);
      logic [31:0] s;
      case (a)
         0: return 32'h00A10204;
         1: return 32'h02010003;
         2: return 32768;
         3: return 32768;
         4: return 2048;
         5: begin
            s = '0;
            s[0] = (m_st == 2 || m_st == 3);
            s[1] = (m_st == 1);
            s[2] = (m_st == 0);
            s[11:8] = m_hit;
            return s;
         end
         6: return core_pc;
         7: return m_cyc;
         8: return m_ret;
         10: return m_start;
         11: return {28'd0, m_ben};
         12, 13, 14, 15: return m_bka[a-12];
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk) begin
      ncyc++;
      if (!rst_n) begin
         m_st = 0; m_start = '0; m_ben = '0; m_hit = '0; m_cyc = 0; m_ret = 0;
         for (int i = 0; i < 4; i++) m_bka[i] = '0;
      end else begin
         logic [5:0] c;
         logic [3:0] hv;
         logic       ren;
         int         nst;
         c   = (reg_wr && reg_addr == 9) ? reg_wdata[5:0] : 6'd0;
         hv  = m_hitv();
         ren = m_run();
         nst = m_st;
         if (m_st == 0) nst = 1;
         else if (c[0]) nst = 0;
         else if (m_st == 1) begin
            if (c[2]) nst = 1; else if (c[3]) nst = 3; else if (c[1]) nst = 2;
         end else if (m_st == 2) begin
            if (c[2] || hv != 0) nst = 1;
         end else begin
            if (c[2] || core_retire) nst = 1;
         end
         m_hit = (c[5] ? 4'd0 : m_hit) | ((m_st == 2) ? hv : 4'd0);
         if (c[4] || c[0]) begin
            m_cyc = 0; m_ret = 0;
         end else begin
            if (m_st == 2 && m_cyc < 255) m_cyc++;
            if (core_retire && ren && m_ret < 255) m_ret++;
         end
         if (reg_wr) begin
            if (reg_addr == 10) m_start = reg_wdata;
            if (reg_addr == 11) m_ben = reg_wdata[3:0];
            if (reg_addr >= 12 && reg_addr <= 15) m_bka[reg_addr-12] = reg_wdata;
         end
         m_st = nst;
      end
      // simple core: load start in reset, advance on permitted retire
      if (core_rst) core_pc <= core_start_pc;
      else if (core_retire && core_run_en) core_pc <= core_pc + 32'd4;
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, ncyc);
      end
   endtask

   function automatic string rd_tag(input int a);
      if (a <= 4) return "R1 id/caps read";
      if (a == 5 || a == 6) return "R10 status/pc read";
      if (a == 7 || a == 8) return "R7 counter read";
      if (a >= 10 && a <= 15) return "R6 config read";
      return "R8 unmapped/command read";
   endfunction

   task automatic compare_all();
      chk("R3 core_run_en", {31'd0, core_run_en}, {31'd0, m_run()});
      chk("R2 core_rst", {31'd0, core_rst}, {31'd0, m_st == 0});
      chk("R4 core_cg_en", {31'd0, core_cg_en}, {31'd0, m_st == 1});
      chk("R2 core_start_pc", core_start_pc, m_start);
      chk(rd_tag(int'(reg_addr)), reg_rdata, m_read(int'(reg_addr)));
   endtask

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         compare_all();
         case (ret_mode)
            1: core_retire = 1'b1;
            2: core_retire = ncyc[0];
            default: core_retire = 1'b0;
         endcase
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
      cyc(1);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, input logic [31:0] exp, input string tag);
      reg_addr = 5'(a);
      #0.2;
      chk(tag, reg_rdata, exp);
   endtask

   // watchdog
   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cyc(3);
      rd(5, 32'h4, "R2 status in reset");
      rst_n = 1'b1;
      cyc(2);
      rd(5, 32'h2, "R10 halted after reset");
      chk("R4 clock gate while halted", {31'd0, core_cg_en}, 32'd1);

      // R1 identification and capabilities
      rd(0, 32'h00A10204, "R1 id word");
      rd(1, 32'h02010003, "R1 caps word");
      rd(2, 32'd32768, "R1 imem size");
      rd(3, 32'd32768, "R1 dmem size");
      rd(4, 32'd2048, "R1 pmem size");

      // R8 read-only and unmapped
      wr(0, 32'hFFFF_FFFF);
      wr(7, 32'h55);
      rd(0, 32'h00A10204, "R8 id write ignored");
      rd(7, 32'h0, "R8 counter write ignored");
      rd(9, 32'h0, "R8 command reads zero");
      rd(20, 32'h0, "R8 unmapped offset 20");
      rd(31, 32'h0, "R8 unmapped offset 31");

      // R2 reset command loads start address
      wr(10, 32'h100);
      wr(9, 32'h1);
      chk("R2 core_rst after reset cmd", {31'd0, core_rst}, 32'd1);
      chk("R2 start pc shown", core_start_pc, 32'h100);
      cyc(1);
      rd(6, 32'h100, "R10 pc loaded from start");
      rd(5, 32'h2, "R2 halted after reset cmd");

      // R3 run, R7 counting
      ret_mode = 2;
      wr(9, 32'h2);
      rd(5, 32'h1, "R3 running status");
      cyc(10);
      ret_mode = 0;
      wr(9, 32'h4);
      rd(5, 32'h2, "R3 halted after stop");
      rd(7, 32'd11, "R7 cycles counted while running");
      cyc(3);
      rd(7, 32'd11, "R7 no counting while halted");

      // R5 step
      wr(9, 32'h3F & 32'h8);
      cyc(3);
      rd(5, 32'h1, "R5 stepping waits for retire");
      ret_mode = 1;
      cyc(1);
      ret_mode = 0;
      cyc(1);
      rd(5, 32'h2, "R5 halted after one retire");

      // R6 breakpoint
      wr(9, 32'h1);
      cyc(1);
      wr(12, 32'h108);
      wr(13, 32'h114);
      wr(11, 32'h2);
      ret_mode = 1;
      wr(9, 32'h2);
      cyc(8);
      rd(6, 32'h114, "R6 stopped at breakpoint pc");
      rd(5, 32'h202, "R6 sticky hit bit 9");
      chk("R6 run_en low at breakpoint", {31'd0, core_run_en}, 32'd0);
      wr(9, 32'h8);
      cyc(2);
      rd(6, 32'h118, "R5 step off breakpoint");
      rd(5, 32'h202, "R6 sticky kept");
      wr(9, 32'h20);
      rd(5, 32'h2, "R6 sticky cleared");
      ret_mode = 0;

      // R9 priority
      wr(9, 32'hE);
      rd(5, 32'h2, "R9 halt beats step and start");
      wr(9, 32'hA);
      rd(5, 32'h1, "R9 step beats start");
      wr(9, 32'h4);
      wr(9, 32'h5);
      rd(5, 32'h4, "R9 reset beats halt");
      cyc(1);

      // R7 saturation and clear
      wr(11, 32'h0);
      ret_mode = 1;
      wr(9, 32'h2);
      cyc(300);
      wr(9, 32'h4);
      ret_mode = 0;
      rd(7, 32'd255, "R7 cycle counter saturated");
      rd(8, 32'd255, "R7 retire counter saturated");
      wr(9, 32'h10);
      rd(7, 32'd0, "R7 cleared by command");
      rd(8, 32'd0, "R7 retire cleared by command");
      cyc(4);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule